// File: doc/BRIEF.md
# Edge-Qualified Status Register Group

This block watches a vector of live condition signals and turns selected changes on them into sticky event bits. Each condition bit has its own pair of filter bits. One filter bit lets a low-to-high change latch an event and the other lets a high-to-low change latch one. Setting both bits catches either change. Clearing both ignores the bit. Latched events stay set until a host reads them. An enable mask chooses which latched events count toward a single summary output, and a higher-level status aggregator can consume that output.

A host reaches the group through a plain register port with an address, a write strobe, a read strobe, write data and registered read data. The host can program the two filter masks and the enable mask. It can sample the live conditions and collect the event bits, and the read that collects them also empties them. Changes are found by comparing each condition bit with its value one clock earlier. A change that qualifies in the same cycle as a collecting read survives that read.

Top module: `sg_status_group`

## Requirements
- R1: Reading address 0 returns the live condition inputs as sampled at the read edge. A write to address 0 has no effect on what is read back.
- R2: A condition bit going 0 to 1 between consecutive clocks latches its event bit when its bit in the rising mask (address 1) is 1, and does not latch it when that bit is 0.
- R3: A condition bit going 1 to 0 between consecutive clocks latches its event bit when its bit in the falling mask (address 2) is 1, and does not latch it when that bit is 0.
- R4: Each bit filters on its own. With both mask bits set, either direction latches. With neither set, no change latches.
- R5: A latched event bit stays set after its condition returns, and a write to the event address (3) does not change it.
- R6: A read of address 3 returns the event bits, and all of them are cleared on the same clock edge.
- R7: A transition that qualifies on the same edge as a clearing read of address 3 leaves its event bit set after the read.
- R8: The summary output is 1 exactly when some event bit is set whose enable bit (address 4) is also set. It follows changes to either register with no added register stage.
- R9: After reset the rising mask is all ones, and the falling mask, event bits, enable mask, summary and read data are all zero.
- R10: Values written to addresses 1, 2 and 4 read back unchanged from the same addresses.
- R11: Reading an address other than 0 to 4 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_in | input | W | Live condition inputs |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 3 | Register select |
| wr_data | input | W | Host write data |
| rd_data | output | W | Read data, registered, updated on each read |
| summary | output | 1 | OR of enabled event bits |

## Verification
The bench builds the group with its default 16-bit width. It programs the masks so that each nibble takes one filter kind: both directions, rising only, falling only, and neither. A single table of condition steps then exercises all four per-bit behaviours against each other within one vector. The full width also lets the reset default be seen across every bit: all ones in the rising mask and zeros elsewhere. Directed steps cover a transition coinciding with a clearing read, and the enable mask gating the summary.

// File: rtl/sg_pkg.sv
// Package: shared register selects for the status group.
// Assumes a 3-bit host address; unused selects read as zero.
package sg_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_COND   = 3'd0,
        SEL_RISE   = 3'd1,
        SEL_FALL   = 3'd2,
        SEL_EVENT  = 3'd3,
        SEL_ENABLE = 3'd4
    } sel_e;
endpackage

// File: rtl/sg_edge_filter.sv
// Module: per-bit transition detector with rising and falling masks.
// Keeps a copy of the conditions from the previous clock. The reset
// loads the live value, so releasing reset creates no false edge.
module sg_edge_filter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond_in,
    input  logic [W-1:0] rise_mask,
    input  logic [W-1:0] fall_mask,
    output logic [W-1:0] prev_q,
    output logic [W-1:0] hit
);
    // Track last cycle's conditions; reset captures the live inputs too.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= cond_in;
        end else begin
            prev_q <= cond_in;
        end
    end

    // One qualifier per bit: a masked rise or a masked fall.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic up, down;
        assign up     = cond_in[i] & ~prev_q[i];
        assign down   = ~cond_in[i] & prev_q[i];
        assign hit[i] = (up & rise_mask[i]) | (down & fall_mask[i]);
    end
endmodule

// File: rtl/sg_event_reg.sv
// Module: sticky event bits with clear-on-read.
// Assumes the clear is one cycle wide. Hits arriving with the clear win.
module sg_event_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hit,
    input  logic         clear,
    output logic [W-1:0] event_q
);
    logic [W-1:0] kept;

    // Drop old bits on a clearing read, otherwise hold them.
    always_comb begin
        kept = clear ? '0 : event_q;
    end

    // Accumulate new hits on top of what is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            event_q <= '0;
        end else begin
            event_q <= kept | hit;
        end
    end
endmodule

// File: rtl/sg_host_regs.sv
// Module: host-visible masks and the registered read path.
// Assumes single-cycle strobes. Read data changes only on a read.
module sg_host_regs #(
    parameter int W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [sg_pkg::ADDR_W-1:0] addr,
    input  logic [W-1:0]              wr_data,
    input  logic [W-1:0]              cond_in,
    input  logic [W-1:0]              event_q,
    output logic [W-1:0]              rise_mask,
    output logic [W-1:0]              fall_mask,
    output logic [W-1:0]              enable_mask,
    output logic [W-1:0]              rd_data,
    output logic                      evt_clear
);
    import sg_pkg::*;

    sel_e         sel;
    logic [W-1:0] rd_mux;

    assign sel = sel_e'(addr);

    // A read of the event select empties the event bits.
    assign evt_clear = rd_en && (sel == SEL_EVENT);

    // Choose the read source; unmapped selects give zero.
    always_comb begin
        case (sel)
            SEL_COND:   rd_mux = cond_in;
            SEL_RISE:   rd_mux = rise_mask;
            SEL_FALL:   rd_mux = fall_mask;
            SEL_EVENT:  rd_mux = event_q;
            SEL_ENABLE: rd_mux = enable_mask;
            default:    rd_mux = '0;
        endcase
    end

    // Update the writable masks; the other selects ignore writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_mask   <= '1;
            fall_mask   <= '0;
            enable_mask <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_RISE:   rise_mask   <= wr_data;
                SEL_FALL:   fall_mask   <= wr_data;
                SEL_ENABLE: enable_mask <= wr_data;
                default:    ;
            endcase
        end
    end

    // Register the selected value on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/sg_status_group.sv
// Module: top of the edge-qualified status group.
// Joins the transition filter, the event bits and the host registers.
// The summary is combinational from the event and enable registers.
module sg_status_group #(
    parameter int W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              cond_in,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [sg_pkg::ADDR_W-1:0] addr,
    input  logic [W-1:0]              wr_data,
    output logic [W-1:0]              rd_data,
    output logic                      summary
);
    logic [W-1:0] rise_mask, fall_mask, enable_mask;
    logic [W-1:0] prev_q, hit, event_q;
    logic         evt_clear;

    sg_edge_filter #(.W(W)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_in   (cond_in),
        .rise_mask (rise_mask),
        .fall_mask (fall_mask),
        .prev_q    (prev_q),
        .hit       (hit)
    );

    sg_event_reg #(.W(W)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clear   (evt_clear),
        .event_q (event_q)
    );

    sg_host_regs #(.W(W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wr_data     (wr_data),
        .cond_in     (cond_in),
        .event_q     (event_q),
        .rise_mask   (rise_mask),
        .fall_mask   (fall_mask),
        .enable_mask (enable_mask),
        .rd_data     (rd_data),
        .evt_clear   (evt_clear)
    );

    // Any enabled event raises the summary.
    assign summary = |(event_q & enable_mask);
endmodule

// File: rtl/sg_status_group_chk.sv
// Module: property checker for the status group, bound to the top.
// Assumes the bench holds reset for at least two clocks at start.
module sg_status_group_chk #(
    parameter int W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [W-1:0]              cond_in,
    input logic [W-1:0]              prev_q,
    input logic [W-1:0]              rise_mask,
    input logic [W-1:0]              fall_mask,
    input logic [W-1:0]              enable_mask,
    input logic [W-1:0]              event_q,
    input logic                      rd_en,
    input logic [sg_pkg::ADDR_W-1:0] addr,
    input logic [W-1:0]              rd_data,
    input logic                      summary
);
    import sg_pkg::*;

    logic evt_rd;
    assign evt_rd = rd_en && (addr == SEL_EVENT);

    assert_rise_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(cond_in) & ~$past(prev_q) & $past(rise_mask) & ~event_q) == '0));

    assert_fall_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(cond_in) & $past(prev_q) & $past(fall_mask) & ~event_q) == '0));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_rd |=> ((event_q & $past(event_q)) == $past(event_q)));

    assert_read_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd |=> (rd_data == $past(event_q)));

    assert_clear_keeps_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd |=> ((event_q & ~($past(cond_in) ^ $past(prev_q))) == '0));

    assert_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        summary == |(event_q & enable_mask));

    assert_reset_state_R9: assert property (@(posedge clk)
        !rst_n |=> (rise_mask == '1 && fall_mask == '0 && event_q == '0 && enable_mask == '0));
endmodule

bind sg_status_group sg_status_group_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cond_in     (cond_in),
    .prev_q      (prev_q),
    .rise_mask   (rise_mask),
    .fall_mask   (fall_mask),
    .enable_mask (enable_mask),
    .event_q     (event_q),
    .rd_en       (rd_en),
    .addr        (addr),
    .rd_data     (rd_data),
    .summary     (summary)
);

// File: tb/sg_status_group_tb.sv
module sg_status_group_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cond_in = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         summary;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    sg_status_group #(.W(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond_in (cond_in),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .summary (summary)
    );

    // Rows: {next condition, expected event bits}. Rise mask 0x00FF and
    // fall mask 0x0F0F give nibble 0 both, 1 rise, 2 fall, 3 neither.
    localparam logic [31:0] VEC [8] = '{
        {16'hFFFF, 16'h00FF},
        {16'h0000, 16'h0F0F},
        {16'h00F0, 16'h00F0},
        {16'h0F00, 16'h0000},
        {16'h000F, 16'h0F0F},
        {16'hF000, 16'h000F},
        {16'h0000, 16'h0000},
        {16'h5555, 16'h0055}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9 summary", 32'(summary), 32'h0);
        check("R9 rd_data", 32'(rd_data), 32'h0);
        rd(3'd1, v); check("R9 rise mask", 32'(v), 32'hFFFF);
        rd(3'd2, v); check("R9 fall mask", 32'(v), 32'h0);
        rd(3'd4, v); check("R9 enable", 32'(v), 32'h0);
        rd(3'd3, v); check("R9 event", 32'(v), 32'h0);

        // R10 readback
        wr(3'd1, 16'h00FF); wr(3'd2, 16'h0F0F); wr(3'd4, 16'hFFFF);
        rd(3'd1, v); check("R10 rise", 32'(v), 32'h00FF);
        rd(3'd2, v); check("R10 fall", 32'(v), 32'h0F0F);
        rd(3'd4, v); check("R10 enable", 32'(v), 32'hFFFF);

        // R2 R3 R4 R6 R8 table walk
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cond_in = VEC[i][31:16];
            @(negedge clk);
            check($sformatf("R8 summary row %0d", i), 32'(summary), 32'(VEC[i][15:0] != 0));
            rd(3'd3, v);
            check($sformatf("R2 R3 R4 R6 event row %0d", i), 32'(v), 32'(VEC[i][15:0]));
            check($sformatf("R6 cleared row %0d", i), 32'(summary), 32'h0);
        end
        rd(3'd3, v); check("R6 empty after read", 32'(v), 32'h0);

        // R1 live condition, write ignored
        @(negedge clk); cond_in = 16'hA5C3;
        rd(3'd0, v); check("R1 cond", 32'(v), 32'hA5C3);
        wr(3'd0, 16'h1234);
        rd(3'd0, v); check("R1 write ignored", 32'(v), 32'hA5C3);
        rd(3'd3, v);
        @(negedge clk); cond_in = 16'h0000;
        rd(3'd3, v);

        // R11 unmapped address
        rd(3'd5, v); check("R11 addr5", 32'(v), 32'h0);
        rd(3'd7, v); check("R11 addr7", 32'(v), 32'h0);

        // R5 sticky and write to event ignored
        wr(3'd1, 16'hFFFF); wr(3'd2, 16'h0000);
        @(negedge clk); cond_in = 16'h0010;
        @(negedge clk); cond_in = 16'h0000;
        wr(3'd3, 16'h0000);
        repeat (2) @(negedge clk);
        check("R5 summary held", 32'(summary), 32'h1);
        rd(3'd3, v); check("R5 sticky event", 32'(v), 32'h0010);

        // R7 new transition coinciding with clearing read
        @(negedge clk); cond_in = 16'h0001;
        @(negedge clk); cond_in = 16'h0003; rd_en = 1'b1; addr = 3'd3;
        @(negedge clk); rd_en = 1'b0;
        check("R7 read old", 32'(rd_data), 32'h0001);
        rd(3'd3, v); check("R7 new kept", 32'(v), 32'h0002);

        // R8 enable gating, no extra stage
        @(negedge clk); cond_in = 16'h0007;
        wr(3'd4, 16'h0002);
        check("R8 gated off", 32'(summary), 32'h0);
        @(negedge clk); wr_en = 1'b1; addr = 3'd4; wr_data = 16'h0004;
        @(negedge clk); wr_en = 1'b0;
        check("R8 gated on", 32'(summary), 32'h1);
        rd(3'd3, v); check("R8 event", 32'(v), 32'h0004);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule